// File: doc/BRIEF.md
# Memory-Mapped Console Receiver and Transmitter

This block is a character device that sits on a simple processor bus. It has one receive channel, fed by a keyboard-like byte source, and one transmit channel, which drains into a display-like byte sink. Software sees four 32-bit words at a fixed base address. There is one control word and one data word for each direction.

On the receive side, each incoming byte is latched and a ready flag is raised. If software has enabled it, an interrupt line is also raised. Reading the receive data word takes the byte and drops the flag. A byte that arrives before the previous one has been taken overwrites it and sets a sticky overrun flag.

On the transmit side, software polls a ready flag and then writes the data word. The low byte of that write is offered to the sink with a valid/accept handshake. The flag stays low for at least a parameterised hold time, and also until the sink has taken the byte.

Top module: `console_io`

## Requirements
- R1: After reset, the receive control word reads 0 and the transmit control word reads 1. `irq` and `tx_valid` are both low.
- R2: When `rx_valid` is high at a clock edge, `rx_byte` is captured. From the next cycle, the receive data word (BASE+4) reads the byte zero-extended, and the receive ready flag (bit 0 of BASE+0) is 1.
- R3: A read of BASE+4 with `bus_re` high clears the ready flag in the following cycle. If a byte arrives in that same cycle, the new byte is stored, the flag stays 1 and no overrun is recorded.
- R4: In the receive control word, only bit 1 (interrupt enable) is writable. Bits 0 and 2 ignore writes, and bits 31..3 always read 0.
- R5: `irq` is high exactly while the receive ready flag and the interrupt enable bit are both 1.
- R6: When a byte arrives while the ready flag is 1 and no data read happens in that cycle, the byte replaces the stored one and the overrun flag (bit 2 of BASE+0) sets. The overrun flag stays set until a read of BASE+0 with `bus_re` high, and it reads as 0 after that read.
- R7: A write to BASE+12 while the transmitter is ready places bits 7..0 of the write data on `tx_byte`. `tx_valid` is high from the next cycle until a cycle in which `tx_accept` is high, and `tx_byte` holds steady throughout.
- R8: Bit 0 of BASE+8 (transmit ready) goes to 0 after an accepted write. It returns to 1 in the cycle after both of these hold: TX_HOLD cycles have elapsed since the write, and the sink has accepted the byte.
- R9: A write to BASE+12 while transmit ready is 0 is ignored: `tx_byte`, `tx_valid` and the ready timing are unchanged.
- R10: Addresses other than the four words, and unaligned addresses, read as 0 and ignore writes. The write-only transmit data word reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_re | input | 1 | Read strobe; qualifies read side effects |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| rx_valid | input | 1 | Incoming byte strobe |
| rx_byte | input | 8 | Incoming byte |
| tx_valid | output | 1 | Outgoing byte offered to the sink |
| tx_byte | output | 8 | Outgoing byte |
| tx_accept | input | 1 | Sink takes the offered byte |
| irq | output | 1 | Receive interrupt request |

## Verification
The contested cycle is the one in which a new byte arrives while software is reading the receive data word. In that cycle, clearing the ready flag, capturing the new byte and flagging an overrun all compete. The random phase raises `rx_valid` often while issuing reads of BASE+4, so the collision occurs many times. A directed step forces the collision once with the interrupt enabled. A reference model in the bench, stepped on the same inputs, predicts the ready, overrun and interrupt state. The cycles after the collision are judged by that prediction.

// File: rtl/console_pkg.sv
// Shared definitions for the console device: register select codes and
// bit positions inside the control words. Assumes 32-bit word spacing.
package console_pkg;
    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_RXCTL = 3'd1,
        SEL_RXDAT = 3'd2,
        SEL_TXCTL = 3'd3,
        SEL_TXDAT = 3'd4
    } csel_e;

    localparam int RXC_READY = 0;
    localparam int RXC_IE    = 1;
    localparam int RXC_OVR   = 2;
    localparam int TXC_READY = 0;
    localparam int BYTE_W    = 8;
endpackage

// File: rtl/console_decode.sv
// Address decoder: maps a bus byte address onto one of the four device words.
// Assumes BASE is 16-byte aligned; unaligned or foreign addresses give SEL_NONE.
module console_decode
    import console_pkg::*;
#(
    parameter int              ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output csel_e             sel
);
    logic in_window;

    // Window match: upper bits equal the base, word aligned.
    assign in_window = (addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]) && (addr[1:0] == 2'b00);

    // Word select from address bits 3..2.
    always_comb begin
        sel = SEL_NONE;
        if (in_window) begin
            case (addr[3:2])
                2'd0:    sel = SEL_RXCTL;
                2'd1:    sel = SEL_RXDAT;
                2'd2:    sel = SEL_TXCTL;
                default: sel = SEL_TXDAT;
            endcase
        end
    end
endmodule

// File: rtl/console_rx.sv
// Receive channel: holds the last byte, its ready flag, the interrupt enable
// and the sticky overrun flag. Assumes strobes are single-cycle qualified.
module console_rx
    import console_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arrive,
    input  logic [BYTE_W-1:0] arrive_byte,
    input  logic              take,
    input  logic              ctl_read,
    input  logic              ie_wr,
    input  logic              ie_val,
    output logic              ready,
    output logic              ie,
    output logic              ovr,
    output logic [BYTE_W-1:0] data
);
    // Byte holder: every arrival overwrites the stored byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      data <= '0;
        else if (arrive) data <= arrive_byte;
    end

    // Ready flag: arrival wins over a simultaneous take.
    always_ff @(posedge clk) begin
        if (!rst_n)      ready <= 1'b0;
        else if (arrive) ready <= 1'b1;
        else if (take)   ready <= 1'b0;
    end

    // Overrun flag: set on unread overwrite, cleared by a control read.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ovr <= 1'b0;
        else if (arrive && ready && !take)  ovr <= 1'b1;
        else if (ctl_read)                  ovr <= 1'b0;
    end

    // Interrupt enable: the only software-writable receive bit.
    always_ff @(posedge clk) begin
        if (!rst_n)     ie <= 1'b0;
        else if (ie_wr) ie <= ie_val;
    end
endmodule

// File: rtl/console_tx.sv
// Transmit channel: latches a byte on an accepted write, offers it to the sink
// and keeps ready low for TX_HOLD cycles and until the sink accepts.
// Assumes the sink may accept in any cycle while tx_valid is high.
module console_tx
    import console_pkg::*;
#(
    parameter int TX_HOLD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              accept,
    output logic              ready,
    output logic              valid,
    output logic [BYTE_W-1:0] byte_q
);
    localparam int CNT_W = (TX_HOLD < 1) ? 1 : $clog2(TX_HOLD + 1);

    logic go;
    logic pending;
    logic hold_done;

    assign go = wr_req && ready;

    // Hold timer: present only when a nonzero hold is configured.
    generate
        if (TX_HOLD > 0) begin : g_hold
            logic [CNT_W-1:0] cnt;
            // Count down from TX_HOLD after each accepted write.
            always_ff @(posedge clk) begin
                if (!rst_n)        cnt <= '0;
                else if (go)       cnt <= CNT_W'(TX_HOLD);
                else if (cnt != 0) cnt <= cnt - 1'b1;
            end
            assign hold_done = (cnt == '0);
        end else begin : g_nohold
            assign hold_done = 1'b1;
        end
    endgenerate

    // Pending flag: set by a write, cleared when the sink accepts.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pending <= 1'b0;
        else if (go)                 pending <= 1'b1;
        else if (pending && accept)  pending <= 1'b0;
    end

    // Outgoing byte register: loaded only by an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)  byte_q <= '0;
        else if (go) byte_q <= wr_byte;
    end

    assign valid = pending;
    assign ready = !pending && hold_done;
endmodule

// File: rtl/console_io.sv
// Top of the console device: decodes bus accesses, routes strobes to the
// receive and transmit channels and builds the read data word.
// Assumes DATA_W >= 8 and one bus access per cycle.
module console_io
    import console_pkg::*;
#(
    parameter int                ADDR_W  = 32,
    parameter int                DATA_W  = 32,
    parameter logic [ADDR_W-1:0] BASE    = 32'hFFFF_0000,
    parameter int                TX_HOLD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic              tx_accept,
    output logic              irq
);
    csel_e sel;
    logic rx_take, rx_ctl_read, rx_ie_write, tx_wr_req;
    logic rx_ready, rx_ie, rx_ovr, tx_ready;
    logic [BYTE_W-1:0] rx_data;

    console_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    // Access strobes derived from the selected word.
    assign rx_take     = bus_re && (sel == SEL_RXDAT);
    assign rx_ctl_read = bus_re && (sel == SEL_RXCTL);
    assign rx_ie_write = bus_we && (sel == SEL_RXCTL);
    assign tx_wr_req   = bus_we && (sel == SEL_TXDAT);

    console_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .arrive      (rx_valid),
        .arrive_byte (rx_byte),
        .take        (rx_take),
        .ctl_read    (rx_ctl_read),
        .ie_wr       (rx_ie_write),
        .ie_val      (bus_wdata[RXC_IE]),
        .ready       (rx_ready),
        .ie          (rx_ie),
        .ovr         (rx_ovr),
        .data        (rx_data)
    );

    console_tx #(.TX_HOLD(TX_HOLD)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (tx_wr_req),
        .wr_byte (bus_wdata[BYTE_W-1:0]),
        .accept  (tx_accept),
        .ready   (tx_ready),
        .valid   (tx_valid),
        .byte_q  (tx_byte)
    );

    // Read mux: unused bits and unmapped words read as zero.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_RXCTL: begin
                bus_rdata[RXC_READY] = rx_ready;
                bus_rdata[RXC_IE]    = rx_ie;
                bus_rdata[RXC_OVR]   = rx_ovr;
            end
            SEL_RXDAT: bus_rdata[BYTE_W-1:0] = rx_data;
            SEL_TXCTL: bus_rdata[TXC_READY]  = tx_ready;
            default:   bus_rdata = '0;
        endcase
    end

    // Interrupt request: ready byte with interrupts enabled.
    assign irq = rx_ready && rx_ie;
endmodule

// File: rtl/console_io_checker.sv
// Property checker for console_io, attached by bind. Observes channel state
// and bus strobes; holds no state of its own.
module console_io_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_take,
    input logic       rx_ie_write,
    input logic       rx_ready,
    input logic       rx_ovr,
    input logic       irq,
    input logic       tx_wr_req,
    input logic       tx_ready,
    input logic       tx_valid,
    input logic       tx_accept,
    input logic [7:0] tx_byte
);
    // R2: an arrival always leaves a ready byte.
    assert_rx_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_ready);

    // R3: a data read with no arrival empties the receiver.
    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_take && !rx_valid) |=> !rx_ready);

    // R5: a raised request persists until taken or disabled.
    assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rx_take && !rx_ie_write) |=> irq);

    // R6: unread overwrite sets the overrun flag.
    assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !rx_take) |=> rx_ovr);

    // R7: an offered byte stays offered and steady until accepted.
    assert_tx_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_accept) |=> (tx_valid && $stable(tx_byte)));

    // R8: an accepted write makes the transmitter busy.
    assert_tx_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_req && tx_ready) |=> (!tx_ready && tx_valid));

    // R9: a write while busy leaves the outgoing byte unchanged.
    assert_tx_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_req && !tx_ready) |=> $stable(tx_byte));
endmodule

bind console_io console_io_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_take     (rx_take),
    .rx_ie_write (rx_ie_write),
    .rx_ready    (rx_ready),
    .rx_ovr      (rx_ovr),
    .irq         (irq),
    .tx_wr_req   (tx_wr_req),
    .tx_ready    (tx_ready),
    .tx_valid    (tx_valid),
    .tx_accept   (tx_accept),
    .tx_byte     (tx_byte)
);

// File: tb/console_io_test.sv
`timescale 1ns/1ps
module console_io_test;
    localparam logic [31:0] BASE = 32'hFFFF_0000;
    localparam int          HOLD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_accept = 1'b0;
    logic        irq;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    bit          done = 1'b0;

    // Reference state built from the requirements.
    bit       m_rdy, m_ie, m_ovr, m_pend;
    bit [7:0] m_byte, m_txb;
    int       m_cnt;

    always #2.5 clk = ~clk;

    console_io #(.BASE(BASE), .TX_HOLD(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_accept(tx_accept), .irq(irq)
    );

    function automatic bit m_txrdy();
        return !m_pend && (m_cnt == 0);
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] a);
        if (a == BASE)         return {29'd0, m_ovr, m_ie, m_rdy};
        if (a == BASE + 32'd4) return {24'd0, m_byte};
        if (a == BASE + 32'd8) return {31'd0, m_txrdy()};
        return 32'd0;
    endfunction

    function automatic string tag_for(input logic [31:0] a);
        if (a == BASE)         return "R4/R6 rx control";
        if (a == BASE + 32'd4) return "R2 rx data";
        if (a == BASE + 32'd8) return "R8 tx control";
        return "R10 unmapped or write-only";
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_rdy = 0; m_ie = 0; m_ovr = 0; m_pend = 0;
        m_byte = 0; m_txb = 0; m_cnt = 0;
    endtask

    // Advance the reference by one clock edge with the given inputs.
    task automatic model_step(input logic [31:0] a, input bit we, input logic [31:0] wd,
                              input bit re, input bit rv, input logic [7:0] rb, input bit acc);
        bit take, cread, go;
        take  = re && (a == BASE + 32'd4);
        cread = re && (a == BASE);
        go    = we && (a == BASE + 32'd12) && m_txrdy();
        if (rv && m_rdy && !take) m_ovr = 1;
        else if (cread)           m_ovr = 0;
        if (rv) begin m_byte = rb; m_rdy = 1; end
        else if (take) m_rdy = 0;
        if (we && a == BASE) m_ie = wd[1];
        if (go) begin
            m_pend = 1; m_cnt = HOLD; m_txb = wd[7:0];
        end else begin
            if (m_cnt > 0) m_cnt--;
            if (m_pend && acc) m_pend = 0;
        end
    endtask

    // One bus cycle: drive, check outputs against the model, clock, update.
    task automatic cyc(input logic [31:0] a, input bit we, input logic [31:0] wd,
                       input bit re, input bit rv, input logic [7:0] rb, input bit acc);
        bus_addr = a; bus_we = we; bus_wdata = wd; bus_re = re;
        rx_valid = rv; rx_byte = rb; tx_accept = acc;
        #1;
        check(bus_rdata, exp_read(a), tag_for(a));
        check({31'd0, irq}, {31'd0, m_rdy && m_ie}, "R5 irq");
        check({31'd0, tx_valid}, {31'd0, m_pend}, "R7 tx_valid");
        if (m_pend) check({24'd0, tx_byte}, {24'd0, m_txb}, "R7/R9 tx_byte");
        @(posedge clk);
        model_step(a, we, wd, re, rv, rb, acc);
        @(negedge clk);
        bus_we = 0; bus_re = 0; rx_valid = 0; tx_accept = 0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    function automatic logic [31:0] pick_addr(input int unsigned k);
        case (k % 6)
            0: return BASE;
            1: return BASE + 32'd4;
            2: return BASE + 32'd8;
            3: return BASE + 32'd12;
            4: return BASE + 32'd16;
            default: return BASE + 32'd5;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        bus_addr = BASE; #1;
        check(bus_rdata, 32'd0, "R1 rx control after reset");
        bus_addr = BASE + 32'd8; #1;
        check(bus_rdata, 32'd1, "R1 tx control after reset");
        check({31'd0, irq}, 32'd0, "R1 irq after reset");
        check({31'd0, tx_valid}, 32'd0, "R1 tx_valid after reset");
        @(negedge clk);

        // R4: only the enable bit takes a write
        cyc(BASE, 1, 32'hFFFF_FFFF, 0, 0, 8'h00, 0);
        bus_addr = BASE; #1;
        check(bus_rdata, 32'h2, "R4 only enable bit writable");
        @(negedge clk);

        // R2/R5: arrival with interrupts enabled
        cyc(BASE + 32'd8, 0, 0, 0, 1, 8'h41, 0);
        check({31'd0, irq}, 32'd1, "R5 irq after arrival");
        // R6: overwrite while ready
        cyc(BASE + 32'd16, 0, 0, 0, 1, 8'h42, 0);
        cyc(BASE, 0, 0, 1, 0, 8'h00, 0);
        cyc(BASE, 0, 0, 0, 0, 8'h00, 0);
        // R3: take and arrival in the same cycle
        cyc(BASE + 32'd4, 0, 0, 1, 1, 8'h5A, 0);
        bus_addr = BASE; #1;
        check(bus_rdata, 32'h3, "R3 collision keeps ready, no overrun");
        check({31'd0, irq}, 32'd1, "R3 irq kept after collision");
        @(negedge clk);
        cyc(BASE + 32'd4, 0, 0, 1, 0, 8'h00, 0);
        cyc(BASE, 0, 0, 0, 0, 8'h00, 0);

        // R7/R8/R9: send, ignored write while busy, late accept
        cyc(BASE + 32'd12, 1, 32'h1234_56A5, 0, 0, 8'h00, 0);
        cyc(BASE + 32'd12, 1, 32'h0000_00FF, 0, 0, 8'h00, 0);
        check({24'd0, tx_byte}, 32'hA5, "R9 busy write ignored");
        for (int i = 0; i < HOLD + 2; i++) cyc(BASE + 32'd8, 0, 0, 0, 0, 8'h00, 0);
        cyc(BASE + 32'd8, 0, 0, 0, 0, 8'h00, 1);
        bus_addr = BASE + 32'd8; #1;
        check(bus_rdata, 32'd1, "R8 ready after hold and accept");
        @(negedge clk);

        // R10: unmapped write has no effect
        cyc(BASE + 32'd16, 1, 32'hFFFF_FFFF, 1, 0, 8'h00, 0);
        cyc(32'h0000_0000, 1, 32'hFFFF_FFFF, 1, 0, 8'h00, 0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            cyc(pick_addr($urandom), ($urandom % 3) == 0, $urandom,
                ($urandom % 2) == 0, ($urandom % 4) == 0, 8'($urandom),
                ($urandom % 3) == 0);
        end

        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end
endmodule